// File: doc/BRIEF.md
# Composite Sync and Gray-Bar Test Generator

This block produces an interlaced, monochrome, 525-line composite video test signal from one free-running clock. It emits a 2-bit level code on every clock. Two output legs carry that code to a resistor DAC. One leg is always driven high or low. The other leg is driven high or released. Together they give four analog levels: sync tip, blank/black, mid gray and light gray.

Each field opens with a vertical interval built from three parts:
- equalizing lines;
- serration lines;
- more equalizing lines.

A group of blank lines follows. The rest of the field is picture. The picture shows horizontal gray bands, and the band level comes from bits 7 and 6 of the frame line number. The second field starts half a line later than a whole line, so its vertical pulses fall mid-line.

The block also gives a field flag, a one-clock line-start strobe and a one-clock field-start strobe. These can trigger a scope on a chosen part of the picture.

Top module: `bar_sync_gen`

## Requirements
- R1: While `rst` is high, `vid_code` is 2'b01 (blank) and `line_stb`, `vstart_stb` and `field_o` are 0. In the first clock after `rst` falls, the block is at clock 0 of frame line 1.
- R2: A line lasts `LINE_CLKS` clocks. `line_stb` is high only on clock 0 of each line.
- R3: A frame holds `LINES` (odd) lines, numbered from 1. `field_o` is 0 from line 1 clock 0 up to the middle of line (LINES+1)/2. It is 1 from clock `LINE_CLKS/2` of that line to the end of the frame.
- R4: Each field is counted in half-lines from its own start. Half-lines 0..5 and 12..17 are equalizing. In them, the first `EQ_CLKS` clocks of each half-line are sync tip (2'b00) and the rest is blank (2'b01).
- R5: Field half-lines 6..11 are serration. In them, each half-line is sync tip except its last `HSYNC_CLKS` clocks, which are blank.
- R6: From field half-line 18 onward, clocks 0..`HSYNC_CLKS`-1 of every line are sync tip.
- R7: Field half-lines 18..39 are blank apart from the line sync of R6.
- R8: From field half-line 40 onward, the active window is clocks `HSYNC_CLKS+BACK_CLKS` up to `LINE_CLKS-FRONT_CLKS`-1. Inside that window the code is 2'b01 when line bit 7 is 0, 2'b10 when bits 7,6 are 1,0, and 2'b11 when both are 1. Clocks outside the window and outside sync are blank.
- R9: `leg_lo` equals code bit 0 (the leg driven high or low). `leg_hi_oe` equals code bit 1 (the enable of the leg that drives high or floats).
- R10: `vstart_stb` is high for one clock at the start of each field. For the first field this is line 1 clock 0. For the second field it is line (LINES+1)/2 clock `LINE_CLKS/2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_code | output | 2 | Level code: 00 tip, 01 blank, 10 mid gray, 11 light gray |
| leg_lo | output | 1 | Level of the always-driven DAC leg |
| leg_hi_oe | output | 1 | Drive enable of the high-or-float DAC leg |
| line_stb | output | 1 | One-clock pulse at each line start |
| vstart_stb | output | 1 | One-clock pulse at each field start |
| field_o | output | 1 | 0 in the first field, 1 in the second |

## Verification
The hardest situation to reach from the ports is the second field's vertical interval. It starts at the middle of a line, deep inside the frame, and the offset half-line boundary there is where an indexing slip would show. The bench shrinks the line length through parameters so that a whole frame fits in a short run. It then walks one full frame plus a wrap, comparing every clock. Random mid-frame resets, held for random lengths, check that the block restarts at line 1 from any state.

// File: rtl/bar_sync_gen.sv
module bar_sync_gen #(
  parameter int LINE_CLKS   = 1716,
  parameter int LINES       = 525,
  parameter int HSYNC_CLKS  = 127,
  parameter int EQ_CLKS     = 62,
  parameter int FRONT_CLKS  = 32,
  parameter int BACK_CLKS   = 85,
  parameter int EQ_LINES    = 3,
  parameter int SER_LINES   = 3,
  parameter int BLANK_LINES = 11
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] vid_code,
  output logic       leg_lo,
  output logic       leg_hi_oe,
  output logic       line_stb,
  output logic       vstart_stb,
  output logic       field_o
);
  localparam int HW  = $clog2(LINE_CLKS);
  localparam int LW  = $clog2(LINES + 1);
  localparam int HLW = LW + 1;
  localparam int F2  = (LINES + 1) / 2;

  localparam logic [HW-1:0] LAST_H  = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] HALF_H  = HW'(LINE_CLKS / 2);
  localparam logic [HW-1:0] EQ_H    = HW'(EQ_CLKS);
  localparam logic [HW-1:0] SERR_H  = HW'(LINE_CLKS / 2 - HSYNC_CLKS);
  localparam logic [HW-1:0] SYNC_H  = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] ACT0_H  = HW'(HSYNC_CLKS + BACK_CLKS);
  localparam logic [HW-1:0] ACT1_H  = HW'(LINE_CLKS - FRONT_CLKS);
  localparam logic [LW-1:0] LAST_L  = LW'(LINES);
  localparam logic [LW-1:0] F2_L    = LW'(F2);

  localparam logic [HLW-1:0] EQA_END = HLW'(2 * EQ_LINES);
  localparam logic [HLW-1:0] SER_END = HLW'(2 * (EQ_LINES + SER_LINES));
  localparam logic [HLW-1:0] EQB_END = HLW'(2 * (2 * EQ_LINES + SER_LINES));
  localparam logic [HLW-1:0] BLK_END = HLW'(2 * (2 * EQ_LINES + SER_LINES + BLANK_LINES));

  logic [HW-1:0]  hcnt;
  logic [LW-1:0]  lcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      lcnt <= LW'(1);
    end else if (hcnt == LAST_H) begin
      hcnt <= '0;
      lcnt <= (lcnt == LAST_L) ? LW'(1) : lcnt + LW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  logic           hh, fld2;
  logic [HW-1:0]  hpos;
  logic [HLW-1:0] hl;
  logic [1:0]     gray;

  assign hh   = (hcnt >= HALF_H);
  assign hpos = hh ? hcnt - HALF_H : hcnt;
  assign fld2 = (lcnt > F2_L) || (lcnt == F2_L && hh);
  assign hl   = fld2 ? {lcnt - F2_L, 1'b0} + HLW'(hh) - HLW'(1)
                     : {lcnt - LW'(1), hh};
  assign gray = {lcnt[7], lcnt[7] ? lcnt[6] : 1'b1};

  always_comb begin
    if (rst)
      vid_code = 2'b01;
    else if (hl < EQA_END || (hl >= SER_END && hl < EQB_END))
      vid_code = (hpos < EQ_H) ? 2'b00 : 2'b01;
    else if (hl < SER_END)
      vid_code = (hpos < SERR_H) ? 2'b00 : 2'b01;
    else if (hcnt < SYNC_H)
      vid_code = 2'b00;
    else if (hl >= BLK_END && hcnt >= ACT0_H && hcnt < ACT1_H)
      vid_code = gray;
    else
      vid_code = 2'b01;
  end

  assign leg_lo     = vid_code[0];
  assign leg_hi_oe  = vid_code[1];
  assign line_stb   = !rst && hcnt == '0;
  assign vstart_stb = !rst && hl == '0 && hpos == '0;
  assign field_o    = !rst && fld2;
endmodule

module bar_sync_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] vid_code,
  input logic       line_stb,
  input logic       vstart_stb,
  input logic       field_o
);
  p_reset_blank_r1: assert property (@(posedge clk)
    rst |-> (vid_code == 2'b01 && !line_stb && !vstart_stb && !field_o));

  p_stb_single_r2: assert property (@(posedge clk) disable iff (rst)
    line_stb |=> !line_stb);

  p_lstart_tip_r6: assert property (@(posedge clk) disable iff (rst)
    line_stb |-> vid_code == 2'b00);

  p_field1_start_r10: assert property (@(posedge clk) disable iff (rst)
    (vstart_stb && !field_o) |-> line_stb);

  p_field2_mid_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(field_o) |-> (vstart_stb && !line_stb));

  p_field_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(field_o) |-> (vstart_stb && line_stb));
endmodule

bind bar_sync_gen bar_sync_gen_chk u_chk (
  .clk(clk), .rst(rst), .vid_code(vid_code), .line_stb(line_stb),
  .vstart_stb(vstart_stb), .field_o(field_o)
);

// File: tb/sim_bar_sync_gen.sv
module sim_bar_sync_gen;
  localparam int LC = 64, HF = 32, HS = 6, EQ = 3, FP = 2, BP = 4, NL = 525;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] vid_code;
  logic leg_lo, leg_hi_oe, line_stb, vstart_stb, field_o;
  int checks = 0, fails = 0;
  int bh = 0, bl = 1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bar_sync_gen #(.LINE_CLKS(LC), .LINES(NL), .HSYNC_CLKS(HS), .EQ_CLKS(EQ),
                 .FRONT_CLKS(FP), .BACK_CLKS(BP)) u0 (
    .clk(clk), .rst(rst), .vid_code(vid_code), .leg_lo(leg_lo),
    .leg_hi_oe(leg_hi_oe), .line_stb(line_stb), .vstart_stb(vstart_stb),
    .field_o(field_o));

  function automatic int abs_half(int h, int ln);
    return 2 * (ln - 1) + ((h >= HF) ? 1 : 0);
  endfunction

  function automatic int fld_half(int h, int ln);
    int a = abs_half(h, ln);
    return (a >= NL) ? a - NL : a;
  endfunction

  function automatic int exp_code(int h, int ln);
    int f = fld_half(h, ln);
    int p = h % HF;
    if (f < 6 || (f >= 12 && f < 18)) return (p < EQ) ? 0 : 1;
    if (f < 12) return (p < HF - HS) ? 0 : 1;
    if (h < HS) return 0;
    if (f >= 40 && h >= HS + BP && h < LC - FP)
      return (ln[7] == 1'b0) ? 1 : (ln[6] ? 3 : 2);
    return 1;
  endfunction

  function automatic string code_req(int h, int ln);
    int f = fld_half(h, ln);
    if (f < 6 || (f >= 12 && f < 18)) return "R4";
    if (f < 12) return "R5";
    if (h < HS) return "R6";
    if (f < 40) return "R7";
    return "R8";
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (line %0d clk %0d)",
               req, what, act, exp, bl, bh);
    end
  endtask

  task automatic check_at(int h, int ln, bit inrst);
    int c, a;
    if (inrst) begin
      chk("R1", "code", vid_code, 1);
      chk("R1", "line_stb", line_stb, 0);
      chk("R1", "vstart_stb", vstart_stb, 0);
      chk("R1", "field", field_o, 0);
    end else begin
      c = exp_code(h, ln);
      a = abs_half(h, ln);
      chk(code_req(h, ln), "code", vid_code, c);
      chk("R9", "leg_lo", leg_lo, c & 1);
      chk("R9", "leg_hi_oe", leg_hi_oe, c >> 1);
      chk("R2", "line_stb", line_stb, (h == 0) ? 1 : 0);
      chk("R3", "field", field_o, (a >= NL) ? 1 : 0);
      chk("R10", "vstart_stb", vstart_stb,
          ((a == 0 || a == NL) && (h % HF) == 0) ? 1 : 0);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(posedge clk); #1;
      bh++;
      if (bh == LC) begin
        bh = 0;
        bl = (bl == NL) ? 1 : bl + 1;
      end
      check_at(bh, bl, 1'b0);
    end
  endtask

  task automatic do_reset(int k);
    @(negedge clk); rst = 1'b1; #1;
    check_at(0, 1, 1'b1);
    repeat (k) begin @(posedge clk); #1; check_at(0, 1, 1'b1); end
    @(negedge clk); rst = 1'b0; #1;
    bh = 0; bl = 1;
    check_at(0, 1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin @(posedge clk); #1; check_at(0, 1, 1'b1); end
    @(negedge clk); rst = 1'b0; #1;
    check_at(0, 1, 1'b0);
    run(NL * LC + 150);
    for (int i = 0; i < 3; i++) begin
      run($urandom_range(20000, 300));
      do_reset($urandom_range(4, 1));
    end
    run(3 * LC);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule